// File: doc/BRIEF.md
# Three-Wire Addressed Tuning Register Receiver

This block receives control words for a radio tuning synthesizer over a slow three-wire serial link: an enable line that frames each transfer, a serial clock, and a data line. Every framed transfer must carry exactly eight bits. The two most significant bits select one of four six-bit slots, and the remaining six bits are the payload. The block samples the serial lines into the system clock domain and finds their edges there. It shifts in bits on the falling serial-clock edge, counts them, and decides at the end of the frame whether the word is kept.

A kept word goes to the slot its address names. Two slots hold control fields: a test code, a switch output level, a two-bit charge-pump current level, a reference step select, a loop-filter input select, a swallow/direct mode bit and a band bit. A third slot stages the low six bits of the main counter. The fourth slot holds the swallow counter value. The main counter value that the divider sees changes only when a swallow-counter word arrives, so a retune is applied in a single step. Words may arrive in any order. Standby is decoded from the two mode bits.

Top module: `tuner_bus_rx`

## Requirements
- R1: After synchronous reset, every output is 0 except `standby_o`, which is 1.
- R2: While `bus_en_i` is high, `bus_sdi_i` is sampled on each falling edge of `bus_sck_i`. The first bit is word bit 7, and word bits 7:6 form the slot address.
- R3: A frame is kept only if exactly 8 falling serial-clock edges occur while enable is high. A frame of 7 or 9 bits changes no output.
- R4: A word is applied only after enable falls. No output changes while the frame is still open.
- R5: Address 00: payload bits 5:3 go to `test_code_o[2:0]`, bit 2 to `sout_o`, bit 1 to `pump_lvl_o[0]` and bit 0 to `ref_sel_o`.
- R6: Address 01: payload bits 5:4 stage main-counter bits 7:6. Bit 3 goes to `filt_sel_o`, bit 2 to `pump_lvl_o[1]`, bit 1 to `swallow_mode_o` and bit 0 to `band_am_o`, all taking effect at once.
- R7: Address 10: the payload stages main-counter bits 5:0. `pc_o` does not change.
- R8: Address 11: the payload goes to `sc_o`. In the same cycle, `pc_o` takes all eight staged bits.
- R9: `standby_o` is 1 exactly when `swallow_mode_o` and `band_am_o` are both 0.
- R10: Serial-clock edges while enable is low neither shift bits in nor change any output. Slots may be written in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Frame enable line (asynchronous) |
| bus_sck_i | input | 1 | Serial clock line (asynchronous) |
| bus_sdi_i | input | 1 | Serial data line (asynchronous) |
| test_code_o | output | 3 | Test code field |
| sout_o | output | 1 | Switch output level |
| pump_lvl_o | output | 2 | Charge-pump current level |
| ref_sel_o | output | 1 | Reference step select |
| filt_sel_o | output | 1 | Loop-filter input select |
| swallow_mode_o | output | 1 | 1 = swallow mode, 0 = direct mode |
| band_am_o | output | 1 | 1 = AM band, 0 = FM band |
| standby_o | output | 1 | Standby decode |
| pc_o | output | 8 | Active main counter value |
| sc_o | output | 6 | Active swallow counter value |

## Verification
The hardest case to reach is a divider value that is half new and half old. It takes a main-counter word that is staged but not yet applied, with other words arriving before the swallow-counter word commits it. The bench checks that `pc_o` holds its old value through every such word. The stimulus interleaves directed sequences with a long seeded random stream of all four addresses. This stream includes 7-bit and 9-bit frames, so staged and active main-counter values often differ when a swallow word lands. Each frame is also checked just before enable falls. Stray serial-clock edges are driven with enable low before a normal word.

// File: rtl/tuner_bus_pkg.sv
package tuner_bus_pkg;
    localparam int WORD_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = WORD_W - ADDR_W;
    localparam int PC_W    = 8;
    localparam int PC_HI_W = PC_W - DATA_W;
    localparam int SC_W    = DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_MISC = 2'b00,
        SLOT_BAND = 2'b01,
        SLOT_PCLO = 2'b10,
        SLOT_SWAL = 2'b11
    } slot_e;

    typedef struct packed {
        slot_e             slot;
        logic [DATA_W-1:0] payload;
    } bus_word_t;

    typedef struct packed {
        logic [2:0] test_code;
        logic       sout;
        logic       curr_lo;
        logic       ref_sel;
    } misc_t;

    typedef struct packed {
        logic [PC_HI_W-1:0] pc_hi;
        logic               filt_sel;
        logic               curr_hi;
        logic               swallow;
        logic               am;
    } band_t;

    function automatic logic is_standby(band_t b);
        return !b.swallow && !b.am;
    endfunction
endpackage

// File: rtl/tuner_bus_sync.sv
module tuner_bus_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            prev_o <= '0;
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_o <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/tuner_bus_shifter.sv
module tuner_bus_shifter
    import tuner_bus_pkg::*;
#(
    parameter int BITS = WORD_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_s,
    input  logic      en_prev,
    input  logic      sck_s,
    input  logic      sck_prev,
    input  logic      sdi_s,
    output logic      word_vld_o,
    output bus_word_t word_o
);
    localparam int CNT_MAX = BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [BITS-1:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             sck_fall, en_fall;

    assign sck_fall = sck_prev & ~sck_s;
    assign en_fall  = en_prev & ~en_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            cnt        <= '0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            word_vld_o <= 1'b0;
            if (en_fall && cnt == CNT_W'(BITS)) begin
                word_vld_o <= 1'b1;
                word_o     <= bus_word_t'(shreg);
            end
            if (!en_s) begin
                cnt <= '0;
            end else if (sck_fall) begin
                shreg <= {shreg[BITS-2:0], sdi_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tuner_bus_regbank.sv
module tuner_bus_regbank
    import tuner_bus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  bus_word_t       word_i,
    output misc_t           misc_o,
    output band_t           band_o,
    output logic [PC_W-1:0] pc_o,
    output logic [SC_W-1:0] sc_o,
    output logic            standby_o
);
    logic [DATA_W-1:0] pclo_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_o     <= '0;
            band_o     <= '0;
            pclo_stage <= '0;
            pc_o       <= '0;
            sc_o       <= '0;
        end else if (vld_i) begin
            unique case (word_i.slot)
                SLOT_MISC: misc_o     <= misc_t'(word_i.payload);
                SLOT_BAND: band_o     <= band_t'(word_i.payload);
                SLOT_PCLO: pclo_stage <= word_i.payload;
                SLOT_SWAL: begin
                    sc_o <= word_i.payload;
                    pc_o <= {band_o.pc_hi, pclo_stage};
                end
                default: ;
            endcase
        end
    end

    assign standby_o = is_standby(band_o);
endmodule

// File: rtl/tuner_bus_rx.sv
module tuner_bus_rx
    import tuner_bus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_en_i,
    input  logic            bus_sck_i,
    input  logic            bus_sdi_i,
    output logic [2:0]      test_code_o,
    output logic            sout_o,
    output logic [1:0]      pump_lvl_o,
    output logic            ref_sel_o,
    output logic            filt_sel_o,
    output logic            swallow_mode_o,
    output logic            band_am_o,
    output logic            standby_o,
    output logic [PC_W-1:0] pc_o,
    output logic [SC_W-1:0] sc_o
);
    logic [2:0] line_s, line_prev;
    logic       word_vld;
    bus_word_t  word_bus;
    misc_t      misc_q;
    band_t      band_q;

    tuner_bus_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({bus_en_i, bus_sck_i, bus_sdi_i}),
        .sync_o (line_s),
        .prev_o (line_prev)
    );

    tuner_bus_shifter #(.BITS(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .en_s      (line_s[2]),
        .en_prev   (line_prev[2]),
        .sck_s     (line_s[1]),
        .sck_prev  (line_prev[1]),
        .sdi_s     (line_s[0]),
        .word_vld_o(word_vld),
        .word_o    (word_bus)
    );

    tuner_bus_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (word_vld),
        .word_i   (word_bus),
        .misc_o   (misc_q),
        .band_o   (band_q),
        .pc_o     (pc_o),
        .sc_o     (sc_o),
        .standby_o(standby_o)
    );

    assign test_code_o    = misc_q.test_code;
    assign sout_o         = misc_q.sout;
    assign ref_sel_o      = misc_q.ref_sel;
    assign pump_lvl_o     = {band_q.curr_hi, misc_q.curr_lo};
    assign filt_sel_o     = band_q.filt_sel;
    assign swallow_mode_o = band_q.swallow;
    assign band_am_o      = band_q.am;
endmodule

// File: rtl/tuner_bus_chk.sv
module tuner_bus_chk (
    input logic       clk,
    input logic       rst,
    input logic       vld,
    input logic [7:0] word,
    input logic [7:0] pc_o,
    input logic [5:0] sc_o,
    input logic [9:0] ctl,
    input logic       standby_o
);
    // R1: outputs cleared, standby selected, when reset releases
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pc_o == 8'd0 && sc_o == 6'd0 && standby_o));

    // R3: an accepted frame produces exactly one commit pulse
    p_single_commit_r3: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R4: without a commit nothing visible moves
    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable({pc_o, sc_o, ctl, standby_o}));

    // R7: only a swallow-slot word may change the active main counter
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (vld && word[7:6] != 2'b11) |=> $stable(pc_o));

    // R8: swallow-slot payload appears on sc_o
    p_sc_load_r8: assert property (@(posedge clk) disable iff (rst)
        (vld && word[7:6] == 2'b11) |=> (sc_o == $past(word[5:0])));
endmodule

bind tuner_bus_rx tuner_bus_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .vld      (word_vld),
    .word     (word_bus),
    .pc_o     (pc_o),
    .sc_o     (sc_o),
    .ctl      ({test_code_o, sout_o, pump_lvl_o, ref_sel_o, filt_sel_o, swallow_mode_o, band_am_o}),
    .standby_o(standby_o)
);

// File: tb/tuner_bus_rx_tb.sv
module tuner_bus_rx_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [2:0] test_code;
    logic       sout, ref_sel, filt_sel, swm, am, stby;
    logic [1:0] pump;
    logic [7:0] pc;
    logic [5:0] sc;

    int total = 0;
    int bad   = 0;
    localparam int PH = 8;

    logic [5:0] e_misc, e_band, e_pclo, e_sc;
    logic [7:0] e_pc;

    always #5 clk = ~clk;

    tuner_bus_rx u_dut (
        .clk(clk), .rst(rst), .bus_en_i(en), .bus_sck_i(sck), .bus_sdi_i(sdi),
        .test_code_o(test_code), .sout_o(sout), .pump_lvl_o(pump), .ref_sel_o(ref_sel),
        .filt_sel_o(filt_sel), .swallow_mode_o(swm), .band_am_o(am), .standby_o(stby),
        .pc_o(pc), .sc_o(sc)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R5 test_code"}, 16'(test_code), 16'(e_misc[5:3]));
        chk({tag, " R5 sout"},      16'(sout),      16'(e_misc[2]));
        chk({tag, " R5/R6 pump"},   16'(pump),      16'({e_band[2], e_misc[1]}));
        chk({tag, " R5 ref_sel"},   16'(ref_sel),   16'(e_misc[0]));
        chk({tag, " R6 filt/mode/band"}, 16'({filt_sel, swm, am}), 16'({e_band[3], e_band[1], e_band[0]}));
        chk({tag, " R9 standby"},   16'(stby),      16'(!e_band[1] && !e_band[0]));
        chk({tag, " R7 pc"},        16'(pc),        16'(e_pc));
        chk({tag, " R8 sc"},        16'(sc),        16'(e_sc));
    endtask

    function automatic void model(input logic [8:0] bits, input int n);
        if (n != 8) return;
        case (bits[7:6])
            2'b00: e_misc = bits[5:0];
            2'b01: e_band = bits[5:0];
            2'b10: e_pclo = bits[5:0];
            default: begin
                e_sc = bits[5:0];
                e_pc = {e_band[5:4], e_pclo};
            end
        endcase
    endfunction

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    // bits[n-1] is sent first (R2)
    task automatic send(input logic [8:0] bits, input int n, input string tag);
        en = 1'b1;
        wait_clk(PH);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            sck = 1'b1;
            wait_clk(PH);
            sck = 1'b0;
            wait_clk(PH);
        end
        check_all({tag, " R4 open-frame"});
        en = 1'b0;
        wait_clk(PH);
        model(bits, n);
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        e_misc = '0; e_band = '0; e_pclo = '0; e_sc = '0; e_pc = '0;
        void'($urandom(32'd20241));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check_all("R1 reset");

        // R7: staged low bits, pc_o held
        send(9'b0_10_000111, 8, "R7 pclo");
        // R6: mode bits immediate, high bits staged
        send(9'b0_01_10_0_0_1_0, 8, "R6 band");
        // R8: swallow word commits pc = 135, sc = 28
        send(9'b0_11_011100, 8, "R8 swal");
        chk("R8 pc value", 16'(pc), 16'd135);
        // R3: wrong lengths discarded
        send(9'b0_0_11_11111, 7, "R3 short");
        send(9'b1_11_111111, 9, "R3 long");
        // R5: misc slot
        send(9'b0_00_101_1_1_1, 8, "R5 misc");
        // R9: both mode bits set, then cleared
        send(9'b0_01_00_1_1_1_1, 8, "R9 am-swallow");
        send(9'b0_01_11_0_0_0_0, 8, "R9 standby");
        // R10: serial clock with enable low
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sck = 1'b1; wait_clk(PH);
            sck = 1'b0; wait_clk(PH);
        end
        check_all("R10 idle clocks");
        send(9'b0_11_000001, 8, "R10 after idle");
        chk("R10 pc high bits", 16'(pc[7:6]), 16'd3);

        // R2/R10: random order, random lengths
        for (int k = 0; k < 60; k++) begin
            int sel, n;
            logic [8:0] w;
            sel = int'($urandom % 8);
            n = (sel == 0) ? 7 : (sel == 1) ? 9 : 8;
            w = 9'($urandom);
            send(w, n, "R2 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule